// File: doc/BRIEF.md
# I2C Register Bank Target

This block is an I2C target that lets a bus host read and write a bank of seventeen 8-bit registers. SCL and SDA are sampled by a much faster system clock through short synchronizer chains. The block never drives SDA high. It only asserts an output-enable that the pad logic turns into a low drive. Every register is also presented on a wide parallel output, so the surrounding logic can use the values directly.

A host writes a register in one transaction of three frames: the device address with a write flag, the register index, and one data byte. Reading takes two transactions. A short write carries only the register index and then stops, which loads an internal pointer. A separate read transaction then returns the byte at that pointer. The pointer survives STOP conditions and never advances on its own, so the same register can be read again and again without reloading it. The pointer clears to 0 on reset. The system clock must run at least eight times faster than SCL.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, every register reads 0x00 on `regs_o` and `sda_oe_o` is low (SDA released).
- R2: A write transaction consists of three frames, each of eight bits sent MSB first and followed by a ninth acknowledge clock. The frames are: 7-bit device address plus R/W=0 in bit 0, the register index, and the data byte. The target pulls SDA low in the ninth clock of all three frames. The data byte then appears on `regs_o[8*i +: 8]` for register i.
- R3: A transaction with the matching device address and R/W=1 is acknowledged. The target then shifts out the addressed register MSB first in the next frame and leaves SDA released during that frame's ninth clock.
- R4: A register index loaded by a two-frame write that ends in STOP is kept across STOP conditions and is not incremented by reads. Back-to-back read transactions return the same register.
- R5: When the device address does not match, the target does not acknowledge. It leaves SDA released for the rest of the transaction, including during read data bits, and changes no register until the next START or STOP.
- R6: A write to a register index of 17 or above is acknowledged in all three frames but changes no register. A read from such an index returns 0x00.
- R7: Only one data byte is accepted per write transaction. A fourth frame is not acknowledged and is not stored in any register.
- R8: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| regs_o | output | NREG*8 | All registers, register i in bits 8*i+7 down to 8*i |

## Verification
A corrupted frame state or bit counter shows up at the very next ninth clock. The acknowledge is then missing or lands in the wrong slot, and the error reaches the bench within one byte frame. A bad register pointer is only visible on the next read transaction, as a wrong byte. For that reason the bench re-reads the pointer after STOPs and after out-of-range accesses. A write strobe that fires at the wrong time shows up on the parallel register outputs as soon as the transaction ends. A check of the whole bank after every transaction catches stray writes.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } rb_state_e;

    // Synchronized bus levels and the conditions derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic in_bank(input logic [7:0] idx, input int nreg);
        return int'(idx) < nreg;
    endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync
    import i2c_rb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev_o.scl      = scl_pipe[STAGES-1];
        ev_o.sda      = sda_pipe[STAGES-1];
        ev_o.scl_rise = ev_o.scl & ~scl_d;
        ev_o.scl_fall = ~ev_o.scl & scl_d;
        ev_o.start    = ev_o.scl & scl_d & sda_d & ~ev_o.sda;
        ev_o.stop     = ev_o.scl & scl_d & ~sda_d & ev_o.sda;
    end

endmodule

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h52
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev_i,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe_o,
    output wr_req_t    wr_o,
    output logic [7:0] ptr_o
);
    rb_state_e  state;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [7:0] tx;
    logic       rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            rd       <= 1'b0;
            ptr_o    <= '0;
            sda_oe_o <= 1'b0;
            wr_o     <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (ev_i.start) begin
                state    <= ST_DEV;
                cnt      <= '0;
                sda_oe_o <= 1'b0;
            end else if (ev_i.stop) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else if (ev_i.scl_rise) begin
                if (state inside {ST_DEV, ST_REG, ST_WDAT}) begin
                    sh  <= {sh[6:0], ev_i.sda};
                    cnt <= cnt + 4'd1;
                end else if (state == ST_RDAT) begin
                    cnt <= cnt + 4'd1;
                end
            end else if (ev_i.scl_fall) begin
                case (state)
                    ST_DEV: if (cnt == 4'd8) begin
                        cnt <= '0;
                        if (sh[7:1] == DEV_ADDR) begin
                            sda_oe_o <= 1'b1;
                            rd       <= sh[0];
                            state    <= ST_DEV_ACK;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                    ST_DEV_ACK: begin
                        if (rd) begin
                            tx       <= rd_data_i;
                            sda_oe_o <= ~rd_data_i[7];
                            state    <= ST_RDAT;
                        end else begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_REG;
                        end
                    end
                    ST_REG: if (cnt == 4'd8) begin
                        cnt      <= '0;
                        ptr_o    <= sh;
                        sda_oe_o <= 1'b1;
                        state    <= ST_REG_ACK;
                    end
                    ST_REG_ACK: begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_WDAT;
                    end
                    ST_WDAT: if (cnt == 4'd8) begin
                        cnt      <= '0;
                        wr_o     <= '{en: 1'b1, addr: ptr_o, data: sh};
                        sda_oe_o <= 1'b1;
                        state    <= ST_WDAT_ACK;
                    end
                    ST_WDAT_ACK: begin
                        sda_oe_o <= 1'b0;
                        state    <= ST_SKIP;
                    end
                    ST_RDAT: begin
                        if (cnt == 4'd8) begin
                            cnt      <= '0;
                            sda_oe_o <= 1'b0;
                            state    <= ST_RACK;
                        end else if (cnt != 4'd0) begin
                            sda_oe_o <= ~tx[3'd7 - cnt[2:0]];
                        end
                    end
                    ST_RACK: state <= ST_SKIP;
                    default: ;
                endcase
            end
        end
    end

    // R8: the enable only moves in a cycle that follows a low synchronized SCL
    p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !$past(ev_i.scl));

    // R5: nothing is driven while idle or ignoring the bus
    p_released_r5: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_IDLE, ST_SKIP}) |-> !sda_oe_o);

    // R4: the pointer survives a STOP
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ev_i.stop |=> $stable(ptr_o));

    // R2: a START always restarts the address frame with SDA released
    p_start_dev_r2: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (state == ST_DEV) && !sda_oe_o);

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile
    import i2c_rb_pkg::*;
#(
    parameter int NREG = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_i,
    input  logic [7:0]        rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic [NREG*8-1:0] regs_o
);
    logic [7:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= '0;
            else if (wr_i.en && wr_i.addr == 8'(g))
                bank[g] <= wr_i.data;
        end
        assign regs_o[g*8 +: 8] = bank[g];
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_addr_i == 8'(i)) rd_data_o = bank[i];
    end

    // R6: an index outside the bank leaves every register as it was
    p_oob_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && !in_bank(wr_i.addr, NREG)) |=> $stable(regs_o));

    // R2: an in-range write lands in the addressed register one cycle later
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && in_bank(wr_i.addr, NREG)) |=>
            (rd_data_o == $past(wr_i.data)) || (rd_addr_i != $past(wr_i.addr)));

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h52,
    parameter int         NREG        = 17,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] regs_o
);
    bus_ev_t    ev;
    wr_req_t    wr;
    logic [7:0] ptr;
    logic [7:0] rd_data;

    i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_rb_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .rd_data_i (rd_data),
        .sda_oe_o  (sda_oe_o),
        .wr_o      (wr),
        .ptr_o     (ptr)
    );

    i2c_rb_regfile #(.NREG(NREG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .rd_addr_i (ptr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

endmodule

// File: tb/i2c_regbank_slave_tb.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb;
    localparam int         NREG = 17;
    localparam logic [6:0] DEV  = 7'h52;
    localparam int         Q    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_regbank_slave u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    typedef struct { string req; logic [7:0] val; } item_t;
    item_t      exp_q[$];
    logic [7:0] act_q[$];
    int n_run = 0, n_fail = 0, viol = 0;
    logic [7:0] mdl [NREG];
    logic prev_oe = 1'b0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pairs each observed bus result with its expectation
    initial begin
        item_t e;
        logic [7:0] a;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                e = exp_q.pop_front();
                a = act_q.pop_front();
                chk(e.req, a, e.val);
            end
        end
    end

    // R8 monitor: enable may only move while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl_m) viol++;
        prev_oe <= sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic qw;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        b = sda_bus; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] v, input string req, input logic exp_ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        exp_q.push_back('{req, {7'b0, exp_ack}});
        rbit(b);
        act_q.push_back({7'b0, ~b});
    endtask

    task automatic recv_byte(input string req, input logic [7:0] exp);
        logic [7:0] v;
        logic b;
        exp_q.push_back('{req, exp});
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        act_q.push_back(v);
        wbit(1'b1);
    endtask

    task automatic write_txn(input logic [6:0] dev, input logic [7:0] idx, input logic [7:0] d,
                             input logic ack_dev, input logic ack_rest, input string req);
        bus_start();
        send_byte({dev, 1'b0}, req, ack_dev);
        send_byte(idx, req, ack_rest);
        send_byte(d, req, ack_rest);
        bus_stop();
    endtask

    task automatic set_ptr(input logic [7:0] idx, input string req);
        bus_start();
        send_byte({DEV, 1'b0}, req, 1'b1);
        send_byte(idx, req, 1'b1);
        bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] exp, input string req);
        bus_start();
        send_byte({DEV, 1'b1}, req, 1'b1);
        recv_byte(req, exp);
        bus_stop();
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++) chk(req, regs[i*8 +: 8], mdl[i]);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", {7'b0, sda_oe}, 8'h00);
        check_bank("R1");

        // R2: plain writes, including the last register
        write_txn(DEV, 8'd3, 8'hA5, 1'b1, 1'b1, "R2");
        mdl[3] = 8'hA5;
        check_bank("R2");
        write_txn(DEV, 8'd16, 8'h3C, 1'b1, 1'b1, "R2");
        mdl[16] = 8'h3C;
        check_bank("R2");

        // R3: pointer setup then read
        set_ptr(8'd3, "R3");
        read_txn(8'hA5, "R3");
        // R4: pointer kept across STOP, no increment
        read_txn(8'hA5, "R4");
        read_txn(8'hA5, "R4");
        set_ptr(8'd16, "R4");
        read_txn(8'h3C, "R4");

        // R5: foreign address, write then read
        write_txn(7'h13, 8'd3, 8'hFF, 1'b0, 1'b0, "R5");
        check_bank("R5");
        bus_start();
        send_byte({7'h13, 1'b1}, "R5", 1'b0);
        recv_byte("R5", 8'hFF);
        bus_stop();
        read_txn(8'h3C, "R5");

        // R6: out-of-range index
        write_txn(DEV, 8'd17, 8'h77, 1'b1, 1'b1, "R6");
        check_bank("R6");
        write_txn(DEV, 8'd200, 8'h99, 1'b1, 1'b1, "R6");
        check_bank("R6");
        set_ptr(8'd17, "R6");
        read_txn(8'h00, "R6");

        // R7: second data byte in one transaction
        bus_start();
        send_byte({DEV, 1'b0}, "R7", 1'b1);
        send_byte(8'd5, "R7", 1'b1);
        send_byte(8'h11, "R7", 1'b1);
        send_byte(8'h22, "R7", 1'b0);
        bus_stop();
        mdl[5] = 8'h11;
        check_bank("R7");
        set_ptr(8'd5, "R7");
        read_txn(8'h11, "R7");

        repeat (20) @(negedge clk);
        chk("R8", 8'(viol), 8'h00);
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule